// File: doc/BRIEF.md
# SRAM Bank Controller with Byte Parity

The block sits on the memory side of a processor bus and steers each single-cycle request onto one of five on-chip SRAM banks (numbered 1 to 5). Bank 2 holds 16 KB and can be moved between an instruction window and a data window by one control bit. The remaining banks keep fixed windows. Every stored byte carries an even-parity bit that is written on every store, and parity checking can be switched on separately for banks 2 to 5.

A request carries address, write data, byte strobes, a write flag and a parity-flip hint. The flip hint stores deliberately wrong parity so that error paths can be exercised. The response follows one cycle later, with read data and an error flag. A mismatch on a checked access, or an address outside every window, completes with the error flag raised. A small register port holds the control word (remap bit and parity enables) and a retention word (per-bank hibernate retention enables, state only). The storage arrays are inside the block, and their depth is a parameter.

Top module: `sram_bank_ctrl`

## Requirements
- R1: After reset the control word reads 0x80000000, the retention word reads 0x00000000 and rsp_valid is 0.
- R2: Only control bits 31 and 21:18 are writable, and all other control bits read 0. Retention bits 1:0 are writable and bits 31:2 read 0. The register select is reg_sel, with 0 = control and 1 = retention. A register write shows on reg_rdata after the next clock edge. A bus access in the same cycle as a register write decodes and checks with the previous register value.
- R3: Bank 1 answers at 0x20002000–0x20003FFF regardless of control bit 31.
- R4: When control bit 31 = 1, bank 2 answers at 0x10000000–0x10003FFF, and 0x20004000–0x20007FFF is unmapped. When bit 31 = 0, the two windows swap roles. Both windows reach the same storage.
- R5: Banks 3, 4 and 5 answer at 0x20008000, 0x2000C000 and 0x20010000, each with a 16 KB window. A bank stores DEPTH_WORDS words, and the word index is address bits [2 +: log2(DEPTH_WORDS)], so addresses alias within a window.
- R6: A request to an address in no window completes with rsp_err = 1 and rsp_rdata = 0, and changes no storage.
- R7: Every request with req_valid = 1 gives rsp_valid = 1 on the next cycle. A write returns rsp_rdata = 0. A read returns the whole stored word, whatever req_be holds.
- R8: On a write, req_be bit i selects data byte [8i+7:8i]. Bytes with a clear strobe keep their old value.
- R9: Every written byte stores even parity (XOR of its 8 bits). When req_par_flip = 1, the stored bit is inverted instead.
- R10: Control bit 18+(n-2) enables checking for bank n (n = 2..5), and bank 1 is never checked. On an enabled bank, a read or a partial write (req_be != 4'hF) checks all four bytes of the stored word. Any mismatch gives rsp_err = 1 and rsp_rdata = 0.
- R11: A partial write that fails its check changes no storage. A full write (req_be = 4'hF) is never checked and rewrites all four parity bits.
- R12: With checking disabled, a word holding bad parity reads back with rsp_err = 0 and its stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte strobes for writes |
| req_wdata | input | 32 | Write data |
| req_par_flip | input | 1 | Store inverted parity for written bytes |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data, zero on writes and errors |
| rsp_err | output | 1 | Bus error response |
| reg_sel | input | 1 | 0 = control word, 1 = retention word |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |

## Verification
A register write and a bus access can fall in the same cycle. The case that matters is a write to the control word that flips the remap bit or a parity enable while a read targets the affected bank. The bench drives both in one cycle. It expects the read to be decoded and checked under the old settings: a hit with correct data before the remap, and no error before the enable. A follow-up read of the same address then shows the new settings taking effect.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;
  localparam int BYTES       = 4;
  localparam int DW          = 8 * BYTES;
  localparam int FIRST_BANK  = 1;
  localparam int LAST_BANK   = 5;
  localparam int CHK_FIRST   = 2;
  localparam int PEN_N       = LAST_BANK - CHK_FIRST + 1;
  localparam int PEN_LSB     = 18;
  localparam int REMAP_BIT   = 31;
  localparam int BANK_IDW    = 3;

  localparam logic [31:0] CTL_RESET = 32'h8000_0000;
  localparam logic [31:0] CTL_WMASK = (32'h1 << REMAP_BIT) | (((32'h1 << PEN_N) - 1) << PEN_LSB);
  localparam logic [31:0] RET_WMASK = 32'h0000_0003;

  localparam logic [31:0] B1_BASE    = 32'h2000_2000;
  localparam int          B1_SZLOG   = 13;
  localparam logic [31:0] B2_INSTR   = 32'h1000_0000;
  localparam logic [31:0] B2_DATA    = 32'h2000_4000;
  localparam logic [31:0] BHI_BASE   = 32'h2000_8000;
  localparam int          BIG_SZLOG  = 14;

  typedef logic [BANK_IDW-1:0] bank_t;

  // Even parity bit of one byte.
  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction

  // Parity bits of all bytes of a word.
  function automatic logic [BYTES-1:0] word_par(input logic [DW-1:0] w);
    logic [BYTES-1:0] p;
    for (int i = 0; i < BYTES; i++) p[i] = even_par(w[8*i +: 8]);
    return p;
  endfunction

  // Bank number for an address, 0 when no window matches.
  function automatic bank_t map_bank(input logic [31:0] a, input logic instr);
    bank_t hit;
    logic [31:0] b2;
    hit = '0;
    b2  = instr ? B2_INSTR : B2_DATA;
    if (a[31:B1_SZLOG] == B1_BASE[31:B1_SZLOG]) hit = bank_t'(1);
    if (a[31:BIG_SZLOG] == b2[31:BIG_SZLOG])    hit = bank_t'(2);
    for (int n = 3; n <= LAST_BANK; n++) begin
      logic [31:0] base;
      base = BHI_BASE + 32'((n - 3) << BIG_SZLOG);
      if (a[31:BIG_SZLOG] == base[31:BIG_SZLOG]) hit = bank_t'(n);
    end
    return hit;
  endfunction

  // Whether parity checking is active for a bank.
  function automatic logic check_on(input bank_t n, input logic [PEN_N-1:0] pen);
    logic on;
    on = 1'b0;
    for (int k = CHK_FIRST; k <= LAST_BANK; k++)
      if (n == bank_t'(k)) on = pen[k - CHK_FIRST];
    return on;
  endfunction
endpackage

// File: rtl/sbc_regs.sv
`timescale 1ns/1ps
module sbc_regs
  import sbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             instr_mode,
  output logic [PEN_N-1:0] par_en
);
  logic [31:0] ctl_q;
  logic [1:0]  ret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      ret_q <= '0;
    end else if (reg_wr) begin
      if (!reg_sel) ctl_q <= reg_wdata & CTL_WMASK;
      else          ret_q <= reg_wdata[1:0] & RET_WMASK[1:0];
    end
  end

  assign reg_rdata  = reg_sel ? {30'b0, ret_q} : ctl_q;
  assign instr_mode = ctl_q[REMAP_BIT];
  assign par_en     = ctl_q[PEN_LSB +: PEN_N];
endmodule

// File: rtl/sbc_decode.sv
`timescale 1ns/1ps
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [31:0]      addr,
  input  logic             instr_mode,
  output logic             hit,
  output bank_t            bank,
  output logic [IDX_W-1:0] idx
);
  assign bank = map_bank(addr, instr_mode);
  assign hit  = (bank != '0);
  assign idx  = addr[2 +: IDX_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[1:0], addr[B1_SZLOG-1:2+IDX_W]};
endmodule

// File: rtl/sbc_bank.sv
`timescale 1ns/1ps
module sbc_bank
  import sbc_pkg::*;
#(
  parameter int DEPTH_WORDS = 16,
  localparam int IDX_W = $clog2(DEPTH_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    rd_data,
  output logic [BYTES-1:0] rd_par,
  input  logic             wr_en,
  input  logic [BYTES-1:0] wr_be,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_flip
);
  logic [DW-1:0]    mem_d [DEPTH_WORDS];
  logic [BYTES-1:0] mem_p [DEPTH_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH_WORDS; w++) begin
        mem_d[w] <= '0;
        mem_p[w] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < BYTES; i++) begin
        if (wr_be[i]) begin
          mem_d[idx][8*i +: 8] <= wr_data[8*i +: 8];
          mem_p[idx][i]        <= even_par(wr_data[8*i +: 8]) ^ wr_flip;
        end
      end
    end
  end

  assign rd_data = mem_d[idx];
  assign rd_par  = mem_p[idx];
endmodule

// File: rtl/sram_bank_ctrl.sv
`timescale 1ns/1ps
module sram_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int DEPTH_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_we,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  input  logic        req_par_flip,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int IDX_W = $clog2(DEPTH_WORDS);

  logic             instr_mode;
  logic [PEN_N-1:0] par_en;

  sbc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .instr_mode (instr_mode),
    .par_en     (par_en)
  );

  logic             acc_hit;
  bank_t            acc_bank;
  logic [IDX_W-1:0] acc_idx;

  sbc_decode #(.IDX_W(IDX_W)) u_dec (
    .addr       (req_addr),
    .instr_mode (instr_mode),
    .hit        (acc_hit),
    .bank       (acc_bank),
    .idx        (acc_idx)
  );

  // Named internal events, observed by the checker.
  logic             wr_commit;
  logic             chk_fire;
  logic             par_bad;
  logic             acc_err;
  logic             partial_wr;
  logic [DW-1:0]    sel_data;
  logic [BYTES-1:0] sel_par;

  logic [DW-1:0]    bank_data [FIRST_BANK:LAST_BANK];
  logic [BYTES-1:0] bank_par  [FIRST_BANK:LAST_BANK];

  for (genvar b = FIRST_BANK; b <= LAST_BANK; b++) begin : g_bank
    logic wr_here;
    assign wr_here = wr_commit && (acc_bank == bank_t'(b));
    sbc_bank #(.DEPTH_WORDS(DEPTH_WORDS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (acc_idx),
      .rd_data (bank_data[b]),
      .rd_par  (bank_par[b]),
      .wr_en   (wr_here),
      .wr_be   (req_be),
      .wr_data (req_wdata),
      .wr_flip (req_par_flip)
    );
  end

  always_comb begin
    sel_data = '0;
    sel_par  = '0;
    for (int b = FIRST_BANK; b <= LAST_BANK; b++) begin
      if (acc_bank == bank_t'(b)) begin
        sel_data = bank_data[b];
        sel_par  = bank_par[b];
      end
    end
  end

  assign partial_wr = req_we && (req_be != {BYTES{1'b1}});
  assign par_bad    = |(sel_par ^ word_par(sel_data));
  assign chk_fire   = req_valid && acc_hit && check_on(acc_bank, par_en)
                      && (!req_we || partial_wr);
  assign acc_err    = req_valid && (!acc_hit || (chk_fire && par_bad));
  assign wr_commit  = req_valid && req_we && acc_hit && !acc_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc_err;
      rsp_rdata <= (req_valid && !req_we && !acc_err) ? sel_data : '0;
    end
  end
endmodule

// File: rtl/sram_bank_ctrl_chk.sv
`timescale 1ns/1ps
module sram_bank_ctrl_chk
  import sbc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_we,
  input logic [3:0]  req_be,
  input logic        reg_sel,
  input logic [31:0] reg_rdata,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        acc_hit,
  input logic        chk_fire,
  input logic        par_bad,
  input logic        wr_commit
);
  p_ctl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> ((reg_rdata & ~CTL_WMASK) == 32'h0));

  p_ret_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[31:2] == 30'h0));

  p_unmapped_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_hit) |=> (rsp_err && rsp_rdata == 32'h0));

  p_unmapped_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> !wr_commit);

  p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_write_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> (rsp_rdata == 32'h0));

  p_bad_par_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fire && par_bad) |=> (rsp_err && rsp_rdata == 32'h0));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fire && par_bad) |-> !wr_commit);

  p_full_nocheck_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_be == 4'hF) |-> !chk_fire);
endmodule

bind sram_bank_ctrl sram_bank_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_we    (req_we),
  .req_be    (req_be),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .acc_hit   (acc_hit),
  .chk_fire  (chk_fire),
  .par_bad   (par_bad),
  .wr_commit (wr_commit)
);

// File: tb/sram_bank_ctrl_tb.sv
`timescale 1ns/1ps
module sram_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_par_flip = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #5 clk = ~clk;

  sram_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .req_par_flip(req_par_flip), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // op: 0 = register write, 1 = bus write, 2 = bus read
  typedef struct packed {
    logic [1:0]  op;
    logic        sel;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic        flip;
    logic        xerr;
    logic [31:0] xrd;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 32'h2000_2000, 4'hF, 32'hA1B2_C3D4, 1'b0, 1'b0, 32'h0},          // R3
    '{2'd2, 1'b0, 32'h2000_2000, 4'h0, 32'h0,        1'b0, 1'b0, 32'hA1B2_C3D4},   // R3 R7
    '{2'd1, 1'b0, 32'h1000_0004, 4'hF, 32'h1122_3344, 1'b0, 1'b0, 32'h0},          // R4
    '{2'd2, 1'b0, 32'h1000_0004, 4'hF, 32'h0,        1'b0, 1'b0, 32'h1122_3344},   // R4
    '{2'd2, 1'b0, 32'h2000_4004, 4'hF, 32'h0,        1'b0, 1'b1, 32'h0},           // R4
    '{2'd0, 1'b0, 32'h0,         4'h0, 32'h7FFF_FFFF, 1'b0, 1'b0, 32'h0},          // R2
    '{2'd2, 1'b0, 32'h2000_4004, 4'hF, 32'h0,        1'b0, 1'b0, 32'h1122_3344},   // R4
    '{2'd2, 1'b0, 32'h1000_0004, 4'hF, 32'h0,        1'b0, 1'b1, 32'h0},           // R4
    '{2'd1, 1'b0, 32'h2000_4004, 4'h1, 32'h0000_00EE, 1'b0, 1'b0, 32'h0},          // R10
    '{2'd2, 1'b0, 32'h2000_4004, 4'hF, 32'h0,        1'b0, 1'b0, 32'h1122_33EE},   // R8 R9
    '{2'd1, 1'b0, 32'h2000_4008, 4'hF, 32'hCAFE_F00D, 1'b1, 1'b0, 32'h0},          // R11
    '{2'd2, 1'b0, 32'h2000_4008, 4'hF, 32'h0,        1'b0, 1'b1, 32'h0},           // R10
    '{2'd1, 1'b0, 32'h2000_4008, 4'hC, 32'h5566_0000, 1'b0, 1'b1, 32'h0},          // R11
    '{2'd0, 1'b0, 32'h0,         4'h0, 32'h0000_0000, 1'b0, 1'b0, 32'h0},          // R2
    '{2'd2, 1'b0, 32'h2000_4008, 4'hF, 32'h0,        1'b0, 1'b0, 32'hCAFE_F00D},   // R11 R12
    '{2'd0, 1'b0, 32'h0,         4'h0, 32'h0004_0000, 1'b0, 1'b0, 32'h0},          // R2
    '{2'd1, 1'b0, 32'h2000_4008, 4'hF, 32'h0102_0304, 1'b0, 1'b0, 32'h0},          // R11
    '{2'd2, 1'b0, 32'h2000_4008, 4'hF, 32'h0,        1'b0, 1'b0, 32'h0102_0304},   // R11
    '{2'd1, 1'b0, 32'h2000_8040, 4'hF, 32'h3333_3333, 1'b0, 1'b0, 32'h0},          // R5
    '{2'd2, 1'b0, 32'h2000_8000, 4'hF, 32'h0,        1'b0, 1'b0, 32'h3333_3333},   // R5
    '{2'd1, 1'b0, 32'h2001_3FFC, 4'hA, 32'hAABB_CCDD, 1'b0, 1'b0, 32'h0},          // R8
    '{2'd2, 1'b0, 32'h2001_3FFC, 4'hF, 32'h0,        1'b0, 1'b0, 32'hAA00_CC00},   // R8
    '{2'd1, 1'b0, 32'h2000_C010, 4'hF, 32'h0F0F_0F0F, 1'b1, 1'b0, 32'h0},          // R9
    '{2'd2, 1'b0, 32'h2000_C010, 4'hF, 32'h0,        1'b0, 1'b0, 32'h0F0F_0F0F},   // R12
    '{2'd0, 1'b0, 32'h0,         4'h0, 32'h0010_0000, 1'b0, 1'b0, 32'h0},          // R2
    '{2'd2, 1'b0, 32'h2000_C010, 4'hF, 32'h0,        1'b0, 1'b1, 32'h0},           // R9 R10
    '{2'd1, 1'b0, 32'h2000_2010, 4'hF, 32'h1234_5678, 1'b1, 1'b0, 32'h0},          // R10
    '{2'd2, 1'b0, 32'h2000_2010, 4'hF, 32'h0,        1'b0, 1'b0, 32'h1234_5678},   // R10 bank 1 unchecked
    '{2'd1, 1'b0, 32'h2000_0000, 4'hF, 32'hDEAD_BEEF, 1'b0, 1'b1, 32'h0},          // R6
    '{2'd2, 1'b0, 32'h2001_4000, 4'hF, 32'h0,        1'b0, 1'b1, 32'h0}            // R6
  };

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic flip,
                        output logic err, output logic [31:0] rd, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be;
    req_wdata = d; req_par_flip = flip;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; req_par_flip = 1'b0;
    err = rsp_err; rd = rsp_rdata; vld = rsp_valid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic e, v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    reg_read(1'b0, r); check("R1 control reset", r, 32'h8000_0000);
    reg_read(1'b1, r); check("R1 retention reset", r, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = VECS[i];
      if (t.op == 2'd0) begin
        reg_write(t.sel, t.data);
      end else begin
        access(t.op == 2'd1, t.addr, t.be, t.data, t.flip, e, r, v);
        check($sformatf("R7 vec%0d valid", i), {31'b0, v}, 32'h1);
        check($sformatf("vec%0d err", i), {31'b0, e}, {31'b0, t.xerr});
        check($sformatf("vec%0d rdata", i), r, t.xrd);
      end
    end

    // R2 register field masks
    reg_write(1'b1, 32'hFFFF_FFFF);
    reg_read(1'b1, r); check("R2 retention mask", r, 32'h0000_0003);
    reg_write(1'b1, 32'h0000_0001);
    reg_read(1'b1, r); check("R2 retention write", r, 32'h0000_0001);
    reg_write(1'b0, 32'hFFFF_FFFF);
    reg_read(1'b0, r); check("R2 control mask", r, 32'h803C_0000);

    // R2 same cycle: remap bit cleared while reading the instruction window
    @(negedge clk);
    reg_sel = 1'b0; reg_wdata = 32'h0; reg_wr = 1'b1;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 32'h1000_0004; req_be = 4'hF;
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0;
    check("R2 same-cycle remap err", {31'b0, rsp_err}, 32'h0);
    check("R2 same-cycle remap data", rsp_rdata, 32'h1122_33EE);
    access(1'b0, 32'h1000_0004, 4'hF, 32'h0, 1'b0, e, r, v);
    check("R2 remap after write", {31'b0, e}, 32'h1);

    // R2 same cycle: bank 4 parity enabled while reading a corrupted word
    @(negedge clk);
    reg_sel = 1'b0; reg_wdata = 32'h0010_0000; reg_wr = 1'b1;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 32'h2000_C010; req_be = 4'hF;
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0;
    check("R2 same-cycle enable err", {31'b0, rsp_err}, 32'h0);
    check("R2 same-cycle enable data", rsp_rdata, 32'h0F0F_0F0F);
    access(1'b0, 32'h2000_C010, 4'hF, 32'h0, 1'b0, e, r, v);
    check("R10 enable after write", {31'b0, e}, 32'h1);

    // R7 idle cycle gives no response
    @(negedge clk);
    check("R7 idle", {31'b0, rsp_valid}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule